// File: doc/BRIEF.md
# Byte-to-Word Packer with Address Sideband

This block assembles a stream of bytes into wide words. Each cycle in which the byte-valid input is high, one byte is accepted. When eight bytes have been accepted, they are presented together on a 64-bit output register with a one-cycle valid pulse. A 5-bit address sampled with the first byte of each word is carried alongside and appears on the output together with the finished word.

A separate restart strobe is forwarded to the output one cycle later. It also synchronously returns the byte position to the start of a word, discarding any partial word. All state changes on the rising clock edge. Reset is synchronous and active high, and all timing is counted in clock cycles.

Top module: `byte_word_packer`

## Requirements
- R1: Every eighth accepted byte (counted from reset or from the last restart) completes a word, and `out_vld` is high for exactly one cycle: the cycle after the edge that accepts that eighth byte.
- R2: In a completed word, the k-th accepted byte (k = 0..7) sits at bits [8k+7:8k], so the first byte occupies bits 7:0 and the eighth occupies bits 63:56.
- R3: Cycles with `in_vld` low accept no byte and neither advance nor disturb the partial word, so idle gaps of any length between bytes give the same word.
- R4: `out_addr` shows the value of `in_addr` that was sampled with the first byte (position 0) of the word, and it is updated together with `out_word`.
- R5: `out_restart` equals `in_restart` delayed by exactly one clock cycle.
- R6: A restart without a byte discards the partial word, and the next accepted byte becomes position 0.
- R7: A restart in the same cycle as an accepted byte discards the partial word, and that byte becomes position 0 (first byte of a new word, with its address captured).
- R8: Between valid pulses, `out_word` and `out_addr` keep their last values.
- R9: After reset, `out_vld`, `out_restart`, `out_word` and `out_addr` are all zero, and the byte position is 0.
- R10: The value of `in_addr` on bytes at positions 1 to 7 has no effect on `out_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge only |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Byte to accept |
| in_vld | input | 1 | Accept `in_byte` this cycle |
| in_addr | input | 5 | Address, sampled with the first byte of a word |
| in_restart | input | 1 | Restart strobe: restarts the byte position and is forwarded |
| out_word | output | 64 | Last completed word |
| out_addr | output | 5 | Address belonging to `out_word` |
| out_vld | output | 1 | One-cycle pulse marking a new word |
| out_restart | output | 1 | Restart strobe delayed by one cycle |

## Verification
The properties assume that every input carries a known level at each rising edge. They also assume reset is held for at least one edge before any check applies, so the history they compare against starts from reset values. The stimulus changes inputs only on falling edges and keeps reset asserted for several cycles at the start. It mixes back-to-back bytes, idle gaps and restart strobes with and without a byte. The one-pulse property depends on a restart with a byte counting as position 0: two completions can then never fall in consecutive cycles.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

    localparam int unsigned PKR_BYTE_W = 8;
    localparam int unsigned PKR_LANES  = 8;
    localparam int unsigned PKR_ADDR_W = 5;

    // What the lane pointer does on the coming edge.
    typedef enum logic [2:0] {
        PA_IDLE   = 3'd0,  // nothing accepted
        PA_STEP   = 3'd1,  // byte accepted, more lanes to fill
        PA_WRAP   = 3'd2,  // byte accepted into the last lane
        PA_CLEAR  = 3'd3,  // restart alone
        PA_RELOAD = 3'd4   // restart with a byte: byte is lane 0
    } ptr_act_e;

    typedef struct packed {
        logic take;   // a byte enters the shift chain
        logic first;  // the byte opens a new word
        logic last;   // the byte closes the word
    } lane_ctl_t;

    function automatic ptr_act_e pick_act(input logic vld,
                                          input logic restart,
                                          input logic at_end);
        ptr_act_e a;
        if (restart)
            a = vld ? PA_RELOAD : PA_CLEAR;
        else if (vld)
            a = at_end ? PA_WRAP : PA_STEP;
        else
            a = PA_IDLE;
        return a;
    endfunction

endpackage

// File: rtl/pkr_seq.sv
module pkr_seq
    import pkr_pkg::*;
#(
    parameter int unsigned LANES = PKR_LANES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      vld,
    input  logic      restart,
    output lane_ctl_t ctl
);
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;
    ptr_act_e         act;

    always_comb begin
        act = pick_act(vld, restart, idx_q == LAST_IDX);
    end

    always_comb begin
        case (act)
            PA_STEP:   idx_d = idx_q + ONE_IDX;
            PA_WRAP:   idx_d = '0;
            PA_CLEAR:  idx_d = '0;
            PA_RELOAD: idx_d = ONE_IDX;
            default:   idx_d = idx_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    always_comb begin
        ctl.take  = vld;
        ctl.first = vld && (restart || (idx_q == '0));
        ctl.last  = (act == PA_WRAP);
    end

endmodule

// File: rtl/pkr_shift.sv
module pkr_shift #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      take,
    input  logic [BYTE_W-1:0]         in_byte,
    output logic [BYTE_W*LANES-1:0]   word_next
);
    // Holds lanes 1..LANES-1 of the shift chain; lane 0 would only be
    // shifted out, so it is never stored.
    logic [BYTE_W-1:0] hold_q [LANES-1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == LANES - 1) begin : g_top
            assign word_next[g*BYTE_W +: BYTE_W] = in_byte;
        end else begin : g_low
            assign word_next[g*BYTE_W +: BYTE_W] = hold_q[g];
        end
    end

    for (genvar k = 0; k < LANES - 1; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)       hold_q[k] <= '0;
            else if (take) hold_q[k] <= word_next[(k+1)*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/pkr_tag.sv
module pkr_tag #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              first,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] addr_next
);
    logic [ADDR_W-1:0] tag_q;

    assign addr_next = first ? in_addr : tag_q;

    always_ff @(posedge clk) begin
        if (rst) tag_q <= '0;
        else     tag_q <= addr_next;
    end

endmodule

// File: rtl/pkr_out.sv
module pkr_out #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              restart,
    input  logic [WORD_W-1:0] word_next,
    input  logic [ADDR_W-1:0] addr_next,
    output logic [WORD_W-1:0] out_word,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_vld,
    output logic              out_restart
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_word    <= '0;
            out_addr    <= '0;
            out_vld     <= 1'b0;
            out_restart <= 1'b0;
        end else begin
            out_vld     <= load;
            out_restart <= restart;
            if (load) begin
                out_word <= word_next;
                out_addr <= addr_next;
            end
        end
    end

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
    import pkr_pkg::*;
#(
    parameter int unsigned BYTE_W = PKR_BYTE_W,
    parameter int unsigned LANES  = PKR_LANES,
    parameter int unsigned ADDR_W = PKR_ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BYTE_W-1:0]       in_byte,
    input  logic                    in_vld,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    in_restart,
    output logic [BYTE_W*LANES-1:0] out_word,
    output logic [ADDR_W-1:0]       out_addr,
    output logic                    out_vld,
    output logic                    out_restart
);
    localparam int unsigned WORD_W = BYTE_W * LANES;

    lane_ctl_t         ctl;
    logic [WORD_W-1:0] word_next;
    logic [ADDR_W-1:0] addr_next;

    pkr_seq #(.LANES(LANES)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .vld     (in_vld),
        .restart (in_restart),
        .ctl     (ctl)
    );

    pkr_shift #(.BYTE_W(BYTE_W), .LANES(LANES)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .take      (ctl.take),
        .in_byte   (in_byte),
        .word_next (word_next)
    );

    pkr_tag #(.ADDR_W(ADDR_W)) tag_i (
        .clk       (clk),
        .rst       (rst),
        .first     (ctl.first),
        .in_addr   (in_addr),
        .addr_next (addr_next)
    );

    pkr_out #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) out_i (
        .clk         (clk),
        .rst         (rst),
        .load        (ctl.last),
        .restart     (in_restart),
        .word_next   (word_next),
        .addr_next   (addr_next),
        .out_word    (out_word),
        .out_addr    (out_addr),
        .out_vld     (out_vld),
        .out_restart (out_restart)
    );

endmodule

// File: rtl/pkr_check.sv
module pkr_check #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              in_restart,
    input logic [WORD_W-1:0] out_word,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_vld,
    input logic              out_restart
);
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);                                              // R1

    AST_VLD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(in_vld) && !$past(in_restart)));                 // R7

    AST_RESTART_FWD_HI: assert property (@(posedge clk) disable iff (rst)
        in_restart |=> out_restart);                                        // R5

    AST_RESTART_FWD_LO: assert property (@(posedge clk) disable iff (rst)
        !in_restart |=> !out_restart);                                      // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_word));                                    // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_addr));                                    // R8

    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);                                              // R3

endmodule

bind byte_word_packer pkr_check #(
    .WORD_W(BYTE_W * LANES),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_restart  (in_restart),
    .out_word    (out_word),
    .out_addr    (out_addr),
    .out_vld     (out_vld),
    .out_restart (out_restart)
);

// File: tb/byte_word_packer_tb_top.sv
module byte_word_packer_tb_top;
    localparam int CLK_NS = 10;
    localparam int BW = 8;
    localparam int NL = 8;
    localparam int AW = 5;
    localparam int WW = BW * NL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] in_byte = '0;
    logic          in_vld = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          in_restart = 1'b0;
    logic [WW-1:0] out_word;
    logic [AW-1:0] out_addr;
    logic          out_vld;
    logic          out_restart;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    int            m_pos = 0;
    logic [WW-1:0] m_word = '0;
    logic [AW-1:0] m_addr = '0;
    logic [WW+AW-1:0] exp_q[$];

    logic          rs_q = 1'b0;
    logic [WW-1:0] last_word = '0;
    logic [AW-1:0] last_addr = '0;

    always #(CLK_NS/2) clk = ~clk;

    byte_word_packer dut_i (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_vld(in_vld),
        .in_addr(in_addr), .in_restart(in_restart), .out_word(out_word),
        .out_addr(out_addr), .out_vld(out_vld), .out_restart(out_restart)
    );

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of input and advance the reference model (R1, R2, R3, R4, R6, R7, R10).
    task automatic drive(input bit v, input logic [BW-1:0] b,
                         input logic [AW-1:0] a, input bit r);
        @(negedge clk);
        in_vld = v; in_byte = b; in_addr = a; in_restart = r;
        if (r) m_pos = 0;
        if (v) begin
            if (m_pos == 0) m_addr = a;
            m_word[m_pos*BW +: BW] = b;
            m_pos++;
            if (m_pos == NL) begin
                exp_q.push_back({m_word, m_addr});
                m_pos = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'hEE, 5'h1F, 1'b0);
    endtask

    always @(posedge clk) rs_q <= in_restart;

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            chk(out_restart == rs_q, "R5 restart forward", WW'(out_restart), WW'(rs_q));
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected out_vld", WW'(out_word), '0);
                end else begin
                    logic [WW+AW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_word == e[WW+AW-1:AW], "R2 word order", out_word, e[WW+AW-1:AW]);
                    chk(out_addr == e[AW-1:0], "R4/R10 address", WW'(out_addr), WW'(e[AW-1:0]));
                end
                last_word = out_word;
                last_addr = out_addr;
            end else begin
                chk(out_word == last_word, "R8 word hold", out_word, last_word);
                chk(out_addr == last_addr, "R8 addr hold", WW'(out_addr), WW'(last_addr));
            end
        end
    end

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state while reset is held
        chk(out_vld == 1'b0, "R9 reset vld", WW'(out_vld), '0);
        chk(out_restart == 1'b0, "R9 reset restart", WW'(out_restart), '0);
        chk(out_word == '0, "R9 reset word", out_word, '0);
        chk(out_addr == '0, "R9 reset addr", WW'(out_addr), '0);
        rst = 1'b0;

        // R1/R2: back-to-back word; R10: addresses differ after first byte
        for (int i = 0; i < NL; i++) drive(1'b1, BW'(8'h11 * (i + 1)), AW'(5'h0A + i), 1'b0);
        idle(3);

        // R3: gaps between bytes
        for (int i = 0; i < NL; i++) begin
            drive(1'b1, BW'(8'hA0 + i), AW'(5'h13 ^ i), 1'b0);
            idle(i % 3);
        end
        idle(2);

        // R6: restart alone after partial word
        for (int i = 0; i < 3; i++) drive(1'b1, 8'hC0 + BW'(i), 5'h05, 1'b0);
        drive(1'b0, 8'h00, 5'h00, 1'b1);
        for (int i = 0; i < NL; i++) drive(1'b1, 8'h30 + BW'(i), AW'(5'h07 + i), 1'b0);
        idle(2);

        // R7: restart with a byte
        for (int i = 0; i < 5; i++) drive(1'b1, 8'hD0 + BW'(i), 5'h02, 1'b0);
        drive(1'b1, 8'h5A, 5'h1C, 1'b1);
        for (int i = 0; i < NL - 1; i++) drive(1'b1, 8'h60 + BW'(i), 5'h01, 1'b0);
        idle(2);

        // R7: consecutive restarts with bytes
        drive(1'b1, 8'h01, 5'h03, 1'b1);
        drive(1'b1, 8'h02, 5'h04, 1'b1);
        for (int i = 0; i < NL - 1; i++) drive(1'b1, 8'h70 + BW'(i), 5'h09, 1'b0);
        // R6: restart right at the last lane prevents completion
        for (int i = 0; i < NL - 1; i++) drive(1'b1, 8'h80 + BW'(i), 5'h0B, 1'b0);
        drive(1'b0, 8'hFF, 5'h00, 1'b1);
        idle(3);

        // mixed stimulus
        for (int i = 0; i < 800; i++)
            drive(($urandom % 4) != 0, BW'($urandom), AW'($urandom), ($urandom % 23) == 0);
        idle(4);

        // R1: every expected word emerged
        chk(exp_q.size() == 0, "R1 missing words", WW'(exp_q.size()), '0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule